// File: doc/BRIEF.md
# Two-level hardware breakpoint trigger

This block watches a processor core as it runs and raises a breakpoint when a programmed condition is met. Each observation cycle carries three values: the address of the instruction that just retired, the address of a bus access, and the data of that access. The block compares the instruction address with a breakpoint PC value. It checks whether the access address lies inside a programmed window. It compares the access data, one byte lane at a time, against a reference value under a per-bit mask. These three matches are combined into a first-level trigger and an optional second-level trigger. The second level is evaluated only after the first level has fired.

Software programs the block through a simple register write port. Select code 0 is the 32-bit trigger definition word. Select codes 1 to 5 are the comparator values: PC, window low bound, window high bound, data reference and data mask. The register is not interlocked. When the final level completes, the block pulses a trace-display strobe. Depending on the response code it may also pulse a halt request or a debug-interrupt request. A two-bit status output shows how far the trigger sequence has advanced.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset, trig_status is 0 (idle) and trace_strobe, halt_req and dbg_irq_req are all 0. This means all breakpoints are disabled.
- R2: A write with cfg_sel=0 stores the definition word. On the next edge it sets trig_status to 1 (armed) if bit 13 of that word is set, and to 0 (idle) otherwise. This discards any earlier trigger status.
- R3: Each level takes its own fields from one half of the definition word. The lower half (offset 0) configures level 1 and the upper half (offset 16) configures level 2. Within a half: bit 13 is the level enable, bits 12:9 are the byte-lane enables, bit 8 enables the window term, and bit 7 enables the PC term. The combining bit is bit 14 for level 1 and bit 15 for level 2. When the combining bit is 0, the level matches on PC AND window AND data. A disabled term counts as true.
- R4: When the combining bit is 1, the level matches on PC OR (window AND data). In this mode a disabled PC term counts as false, so a PC match alone or a window-and-data match alone is enough.
- R5: Data is compared only on byte lanes whose enable bit is set (lane n is data bits 8n+7:8n). Data bits whose mask bit is 1 are ignored. With no lanes enabled, the data term is true.
- R6: The window term is true when low bound <= access address <= high bound, with both bounds inclusive.
- R7: If level 2 is enabled (bit 29), a level-1 match moves trig_status from 1 to 2. Level 2 is checked only on later observation cycles, never on the same one. A level-2 match then moves trig_status to 3.
- R8: When the final level completes, trace_strobe is 1 for exactly one cycle, on the edge after the matching observation. Bits 31:30 of the definition word select the extra response. Code 01 also pulses halt_req and code 10 also pulses dbg_irq_req. Codes 00 and 11 give the strobe only.
- R9: Once trig_status is 3, it holds until the next definition write, and further matches give no more pulses.
- R10: With bit 13 clear, no observation fires a trigger or changes trig_status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 definition, 1 PC, 2 low bound, 3 high bound, 4 data reference, 5 data mask |
| cfg_wdata | input | 32 | Write data |
| obs_vld | input | 1 | Observation cycle valid |
| obs_pc | input | AW | Retired instruction address |
| obs_addr | input | AW | Bus access address |
| obs_data | input | DW | Bus access data |
| trig_status | output | 2 | 0 idle, 1 armed, 2 level 1 hit, 3 complete |
| trace_strobe | output | 1 | One-cycle pulse on every completed trigger |
| halt_req | output | 1 | One-cycle halt request |
| dbg_irq_req | output | 1 | One-cycle debug-interrupt request |

## Verification
The hardest case to reach is the two-level sequence. It needs an observation that matches both levels at once and must advance only to status 2, followed by a separate observation that satisfies level 2 alone. The directed test builds exactly this pair of observations. It then sends a further matching observation to confirm that the completed state emits nothing more. Finally, a definition rewrite must re-arm the trigger. The table walk covers the other combining modes, byte-lane and mask choices, and window edges one observation at a time.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

   typedef enum logic [1:0] {
      TS_IDLE  = 2'd0,
      TS_ARMED = 2'd1,
      TS_WAIT2 = 2'd2,
      TS_DONE  = 2'd3
   } trig_st_e;

   localparam logic [1:0] RSP_SHOW = 2'b00;
   localparam logic [1:0] RSP_HALT = 2'b01;
   localparam logic [1:0] RSP_IRQ  = 2'b10;

   localparam int DEF_W    = 32;
   localparam int HALF_W   = 16;
   localparam int LANE_FLD = 4;

   localparam logic [2:0] SEL_DEF  = 3'd0;
   localparam logic [2:0] SEL_PC   = 3'd1;
   localparam logic [2:0] SEL_LO   = 3'd2;
   localparam logic [2:0] SEL_HI   = 3'd3;
   localparam logic [2:0] SEL_DVAL = 3'd4;
   localparam logic [2:0] SEL_DMSK = 3'd5;

   typedef struct packed {
      logic                en;
      logic [LANE_FLD-1:0] lanes;
      logic                rng_en;
      logic                pc_en;
      logic                or_mode;
   } lvl_cfg_t;

endpackage

// File: rtl/trig_cmp.sv
module trig_cmp
   import dbg_trig_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   localparam int LANES = DW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       sel,
   input  logic [31:0]      wdata,
   input  logic [AW-1:0]    obs_pc,
   input  logic [AW-1:0]    obs_addr,
   input  logic [DW-1:0]    obs_data,
   output logic             pc_hit,
   output logic             rng_hit,
   output logic [LANES-1:0] lane_hit
);

   logic [AW-1:0] pc_q, lo_q, hi_q;
   logic [DW-1:0] dval_q, dmsk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         dval_q <= '0;
         dmsk_q <= '0;
      end else if (we) begin
         case (sel)
            SEL_PC:   pc_q   <= wdata[AW-1:0];
            SEL_LO:   lo_q   <= wdata[AW-1:0];
            SEL_HI:   hi_q   <= wdata[AW-1:0];
            SEL_DVAL: dval_q <= wdata[DW-1:0];
            SEL_DMSK: dmsk_q <= wdata[DW-1:0];
            default: ;
         endcase
      end
   end

   assign pc_hit  = (obs_pc == pc_q);
   assign rng_hit = (obs_addr >= lo_q) && (obs_addr <= hi_q);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_hit[l] =
         ((obs_data[8*l +: 8] ^ dval_q[8*l +: 8]) & ~dmsk_q[8*l +: 8]) == 8'h00;
   end

endmodule

// File: rtl/trig_level.sv
module trig_level
   import dbg_trig_pkg::*;
#(
   parameter int LANES = 4
) (
   input  lvl_cfg_t         cfg,
   input  logic             pc_hit,
   input  logic             rng_hit,
   input  logic [LANES-1:0] lane_hit,
   output logic             hit
);

   logic d_term, r_term, a_term, p_term, comb;

   assign d_term = &(lane_hit | ~cfg.lanes[LANES-1:0]);
   assign r_term = cfg.rng_en ? rng_hit : 1'b1;
   assign a_term = r_term & d_term;

   generate
      if (LANES < LANE_FLD) begin : g_spare
         logic unused_lanes;
         assign unused_lanes = ^cfg.lanes[LANE_FLD-1:LANES];
      end
   endgenerate

   always_comb begin
      if (cfg.or_mode) begin
         p_term = cfg.pc_en & pc_hit;
         comb   = p_term | a_term;
      end else begin
         p_term = cfg.pc_en ? pc_hit : 1'b1;
         comb   = p_term & a_term;
      end
   end

   assign hit = cfg.en & comb;

endmodule

// File: rtl/trig_seq.sv
module trig_seq
   import dbg_trig_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       def_wr,
   input  logic       new_en1,
   input  logic       obs_vld,
   input  logic       l1_hit,
   input  logic       l2_hit,
   input  logic       l2_en,
   input  logic [1:0] rsp,
   output logic [1:0] status,
   output logic       disp,
   output logic       halt,
   output logic       irq
);

   trig_st_e st_q, st_d;
   logic     fire;

   always_comb begin
      st_d = st_q;
      fire = 1'b0;
      if (def_wr) begin
         st_d = new_en1 ? TS_ARMED : TS_IDLE;
      end else if (obs_vld) begin
         case (st_q)
            TS_ARMED:
               if (l1_hit) begin
                  if (l2_en) begin
                     st_d = TS_WAIT2;
                  end else begin
                     st_d = TS_DONE;
                     fire = 1'b1;
                  end
               end
            TS_WAIT2:
               if (l2_hit) begin
                  st_d = TS_DONE;
                  fire = 1'b1;
               end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= TS_IDLE;
         disp <= 1'b0;
         halt <= 1'b0;
         irq  <= 1'b0;
      end else begin
         st_q <= st_d;
         disp <= fire;
         halt <= fire && (rsp == RSP_HALT);
         irq  <= fire && (rsp == RSP_IRQ);
      end
   end

   assign status = st_q;

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
   import dbg_trig_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_sel,
   input  logic [31:0]   cfg_wdata,
   input  logic          obs_vld,
   input  logic [AW-1:0] obs_pc,
   input  logic [AW-1:0] obs_addr,
   input  logic [DW-1:0] obs_data,
   output logic [1:0]    trig_status,
   output logic          trace_strobe,
   output logic          halt_req,
   output logic          dbg_irq_req
);

   localparam int LANES = DW / 8;

   if (AW < 1 || AW > 32) begin : g_bad_aw
      $error("dbg_trig_unit: AW must be 1..32");
   end
   if (DW < 8 || DW > 32 || (DW % 8) != 0) begin : g_bad_dw
      $error("dbg_trig_unit: DW must be 8, 16, 24 or 32");
   end

   logic [DEF_W-1:0] def_q;
   logic             def_wr;
   logic             pc_hit, rng_hit;
   logic [LANES-1:0] lane_hit;
   logic [1:0]       lvl_hit;
   logic             unused_def;

   assign def_wr     = cfg_we && (cfg_sel == SEL_DEF);
   assign unused_def = ^{def_q[6:0], def_q[22:16]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      def_q <= '0;
      else if (def_wr) def_q <= cfg_wdata;
   end

   trig_cmp #(.AW(AW), .DW(DW)) i_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .sel      (cfg_sel),
      .wdata    (cfg_wdata),
      .obs_pc   (obs_pc),
      .obs_addr (obs_addr),
      .obs_data (obs_data),
      .pc_hit   (pc_hit),
      .rng_hit  (rng_hit),
      .lane_hit (lane_hit)
   );

   for (genvar g = 0; g < 2; g++) begin : g_lvl
      localparam int B = HALF_W * g;
      lvl_cfg_t cfg;
      assign cfg = '{en:      def_q[B+13],
                     lanes:   def_q[B+12:B+9],
                     rng_en:  def_q[B+8],
                     pc_en:   def_q[B+7],
                     or_mode: def_q[14+g]};
      trig_level #(.LANES(LANES)) i_level (
         .cfg      (cfg),
         .pc_hit   (pc_hit),
         .rng_hit  (rng_hit),
         .lane_hit (lane_hit),
         .hit      (lvl_hit[g])
      );
   end

   trig_seq i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .def_wr  (def_wr),
      .new_en1 (cfg_wdata[13]),
      .obs_vld (obs_vld),
      .l1_hit  (lvl_hit[0]),
      .l2_hit  (lvl_hit[1]),
      .l2_en   (def_q[HALF_W+13]),
      .rsp     (def_q[31:30]),
      .status  (trig_status),
      .disp    (trace_strobe),
      .halt    (halt_req),
      .irq     (dbg_irq_req)
   );

endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic [2:0] cfg_sel,
   input logic       obs_vld,
   input logic [1:0] trig_status,
   input logic       trace_strobe,
   input logic       halt_req,
   input logic       dbg_irq_req
);

   logic def_wr;
   assign def_wr = cfg_we && (cfg_sel == 3'd0);

   p_def_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      def_wr |=> (trig_status == 2'd0 || trig_status == 2'd1));

   p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trace_strobe |=> !trace_strobe);

   p_halt_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> trace_strobe);

   p_irq_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_irq_req |-> trace_strobe);

   p_resp_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(halt_req && dbg_irq_req));

   p_strobe_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trace_strobe |-> trig_status == 2'd3);

   p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_status == 2'd3 && !def_wr) |=> (trig_status == 2'd3 && !trace_strobe));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_status == 2'd0 && !def_wr) |=> (trig_status == 2'd0 && !trace_strobe));

   p_wait_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_status == 2'd2 && !def_wr) |=> (trig_status == 2'd2 || trig_status == 2'd3));

   p_wait_needs_obs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_status == 2'd1 && !def_wr && !obs_vld) |=> trig_status == 2'd1);

endmodule

bind dbg_trig_unit dbg_trig_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_sel      (cfg_sel),
   .obs_vld      (obs_vld),
   .trig_status  (trig_status),
   .trace_strobe (trace_strobe),
   .halt_req     (halt_req),
   .dbg_irq_req  (dbg_irq_req)
);

// File: tb/test_dbg_trig_unit.sv
module test_dbg_trig_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [31:0] cfg_wdata = '0;
   logic        obs_vld = 1'b0;
   logic [31:0] obs_pc = '0, obs_addr = '0, obs_data = '0;
   logic [1:0]  trig_status;
   logic        trace_strobe, halt_req, dbg_irq_req;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dbg_trig_unit i_dbg_trig_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .obs_vld(obs_vld), .obs_pc(obs_pc),
      .obs_addr(obs_addr), .obs_data(obs_data), .trig_status(trig_status),
      .trace_strobe(trace_strobe), .halt_req(halt_req), .dbg_irq_req(dbg_irq_req)
   );

   typedef struct packed {
      logic [31:0] def, pcv, lo, hi, dv, dm, opc, oad, odt;
      logic [1:0]  st;
      logic [2:0]  rsp;   // {strobe, halt, irq}
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      // R3 AND of PC and window, halt response
      '{32'h4000_2180, 32'h100, 32'h2000, 32'h2FFF, 32'h0, 32'h0, 32'h100, 32'h2000, 32'h0, 2'd3, 3'b110},
      // R6 window miss above high bound
      '{32'h4000_2180, 32'h100, 32'h2000, 32'h2FFF, 32'h0, 32'h0, 32'h100, 32'h3000, 32'h0, 2'd1, 3'b000},
      // R6 high bound inclusive, R8 interrupt response
      '{32'h8000_2180, 32'h100, 32'h2000, 32'h2FFF, 32'h0, 32'h0, 32'h100, 32'h2FFF, 32'h0, 2'd3, 3'b101},
      // R4 OR mode, window alone, R8 code 00
      '{32'h0000_6180, 32'h100, 32'h2000, 32'h2FFF, 32'h0, 32'h0, 32'h104, 32'h2800, 32'h0, 2'd3, 3'b100},
      // R4 OR mode, PC alone, R8 code 11
      '{32'hC000_6180, 32'h100, 32'h2000, 32'h2FFF, 32'h0, 32'h0, 32'h100, 32'h5000, 32'h0, 2'd3, 3'b100},
      // R5 all lanes with low byte masked
      '{32'h4000_3E00, 32'h0, 32'h0, 32'h0, 32'h1234_5678, 32'hFF, 32'h0, 32'h0, 32'h1234_56AA, 2'd3, 3'b110},
      // R5 unmasked bit differs
      '{32'h4000_3E00, 32'h0, 32'h0, 32'h0, 32'h1234_5678, 32'hFF, 32'h0, 32'h0, 32'h1234_57AA, 2'd1, 3'b000},
      // R5 only lane 0 enabled
      '{32'h4000_2200, 32'h0, 32'h0, 32'h0, 32'h55, 32'h0, 32'h0, 32'h0, 32'hFFFF_FF55, 2'd3, 3'b110},
      // R10 enable clear
      '{32'h4000_0180, 32'h100, 32'h2000, 32'h2FFF, 32'h0, 32'h0, 32'h100, 32'h2000, 32'h0, 2'd0, 3'b000},
      // R6 one below low bound
      '{32'h4000_2100, 32'h0, 32'h2000, 32'h2FFF, 32'h0, 32'h0, 32'h0, 32'h1FFF, 32'h0, 2'd1, 3'b000},
      // R4 OR mode, PC disabled, window hit but data miss
      '{32'h0000_6300, 32'h0, 32'h2000, 32'h2FFF, 32'h0, 32'h0, 32'h0, 32'h2000, 32'h1, 2'd1, 3'b000},
      // R5 mask hides differing high nibble
      '{32'h4000_2200, 32'h0, 32'h0, 32'h0, 32'h0F, 32'hF0, 32'h0, 32'h0, 32'hAF, 2'd3, 3'b110}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic obs(input logic [31:0] pc, input logic [31:0] ad, input logic [31:0] dt);
      obs_vld = 1'b1; obs_pc = pc; obs_addr = ad; obs_data = dt;
      @(negedge clk);
      obs_vld = 1'b0;
   endtask

   function automatic logic [31:0] outs();
      return {29'd0, trace_strobe, halt_req, dbg_irq_req};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status", {30'd0, trig_status}, 32'd0);
      chk("R1 outputs", outs(), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         wr(3'd1, VECS[i].pcv);
         wr(3'd2, VECS[i].lo);
         wr(3'd3, VECS[i].hi);
         wr(3'd4, VECS[i].dv);
         wr(3'd5, VECS[i].dm);
         wr(3'd0, VECS[i].def);
         obs(VECS[i].opc, VECS[i].oad, VECS[i].odt);
         chk($sformatf("table %0d status R3/R4/R5/R6/R10", i), {30'd0, trig_status}, {30'd0, VECS[i].st});
         chk($sformatf("table %0d pulses R8", i), outs(), {29'd0, VECS[i].rsp});
         @(negedge clk);
         chk($sformatf("table %0d pulse width R8", i), outs(), 32'd0);
      end

      // R7 two-level sequence: level 1 on PC, level 2 on window, halt
      wr(3'd1, 32'h400);
      wr(3'd2, 32'h8000);
      wr(3'd3, 32'h80FF);
      wr(3'd4, 32'h0);
      wr(3'd5, 32'h0);
      wr(3'd0, 32'h6100_2080);
      chk("R2 armed after write", {30'd0, trig_status}, 32'd1);
      obs(32'h400, 32'h8000, 32'h0);
      chk("R7 level1 hit status", {30'd0, trig_status}, 32'd2);
      chk("R7 no pulse on level1", outs(), 32'd0);
      obs(32'h0, 32'h9000, 32'h0);
      chk("R7 level2 miss holds", {30'd0, trig_status}, 32'd2);
      obs(32'h0, 32'h8010, 32'h0);
      chk("R7 level2 done", {30'd0, trig_status}, 32'd3);
      chk("R8 level2 halt pulse", outs(), 32'b110);
      @(negedge clk);
      chk("R8 single cycle", outs(), 32'd0);
      // R9 completed state holds, no repeat
      obs(32'h400, 32'h8010, 32'h0);
      chk("R9 status holds", {30'd0, trig_status}, 32'd3);
      chk("R9 no further pulse", outs(), 32'd0);
      // R2 rewrite re-arms
      wr(3'd0, 32'h0000_2080);
      chk("R2 rewrite clears", {30'd0, trig_status}, 32'd1);
      wr(3'd0, 32'h0000_0080);
      chk("R2 disabled write idle", {30'd0, trig_status}, 32'd0);
      // R10 disabled level ignores matching PC
      obs(32'h400, 32'h0, 32'h0);
      chk("R10 idle ignores match", {30'd0, trig_status}, 32'd0);
      chk("R10 no pulse", outs(), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule